// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target has left wedged with SDA held low, typically after a transfer was cut off mid-byte. On a one-cycle command strobe it looks at the sensed line levels. If both lines are already high, the bus is idle and the block reports completion at once without touching either line. If SDA is low, it toggles SCL one pulse at a time so the target can clock out the rest of its byte. It stops as soon as SDA is seen high, and it gives up after a parameterised maximum of eight pulses.

After SDA has been released, the block drives a STOP condition to put the bus back to idle. It then raises a recovery-done flag. If SDA is still low after the last permitted pulse, the block raises a sticky failure flag together with done and does not attempt the STOP.

The pulse low and high widths come from two timing fields, counted in ticks of an external prescaler strobe. The block drives the lines open-drain style: a drive output at 1 means "pull the line low". Deciding when recovery is needed, and resetting the controller afterwards, are left to the surrounding logic.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset, both drive outputs, `busy`, `recover_done` and `recover_failed` are 0.
- R2: A strobe on `recover_go` while idle with `sda_in` and `scl_in` both 1 sets `recover_done` on the same clock edge that samples the strobe. No line is driven, `busy` stays 0 and `recover_failed` is 0.
- R3: With `sda_in` low at the strobe, each recovery pulse holds `scl_drive_low` at 1 for `lo_ticks`+1 ticks and then at 0 for `hi_ticks`+1 ticks.
- R4: SDA is sampled on the last tick of each high phase. Pulsing ends at the first pulse whose sample sees SDA high, so a target that lets go of SDA on the rising SCL edge of its k-th pulse (k ≤ 8) receives exactly k pulses.
- R5: If SDA is still low at the end of the eighth high phase, the block sets `recover_failed` and `recover_done`, drives neither line again, and issues no STOP. `recover_failed` is never 1 without `recover_done`.
- R6: After SDA is released, or when SDA is high but SCL is low at the strobe, the block generates one STOP. SCL is pulled low first. SDA is pulled low only while SCL has already been low for a cycle. SCL is then released, and SDA is released while SCL is released. `recover_done` is set when the final release phase ends.
- R7: `recover_done` and `recover_failed` hold their values until the next accepted strobe, which clears them. `recover_done` is 0 whenever `busy` is 1.
- R8: A strobe that arrives while `busy` is 1 is ignored: the pulse count and the outcome of the running recovery are unchanged.
- R9: Neither drive output is 1 while `busy` is 0, and SDA is never pulled low during the recovery pulses.
- R10: With `sda_in` high and `scl_in` low at the strobe, no recovery pulses are issued. The only SCL-low episode is the one belonging to the STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| recover_go | input | 1 | One-cycle recovery command strobe |
| sda_in | input | 1 | Sensed SDA line level |
| scl_in | input | 1 | Sensed SCL line level |
| tick | input | 1 | Prescaled timing strobe; phases count these |
| lo_ticks | input | TW | SCL low phase length minus one, in ticks |
| hi_ticks | input | TW | SCL high phase length minus one, in ticks |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low (STOP generation only) |
| busy | output | 1 | A recovery is in progress |
| recover_done | output | 1 | Sticky completion flag |
| recover_failed | output | 1 | Sticky flag: SDA still low after the last pulse |

## Verification
Every output is registered. A phase change is therefore visible after the edge that samples the closing tick of the phase, and an idle-bus strobe shows `recover_done` after the edge that samples the strobe. The bench drives the strobe and the modelled target's SDA on falling edges, and it samples all outputs on falling edges, half a cycle after the edge that changed them. Phase widths are counted in falling-edge samples. With a tick every cycle, a width must equal its field plus one. With a slower tick, the width must fall in the window that tick alignment allows. Pulse and STOP episodes are counted from edges of the drive outputs and compared with counts computed from the target's release pulse.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PULSE_LO  = 3'd1,
        ST_PULSE_HI  = 3'd2,
        ST_STOP_SCL  = 3'd3,
        ST_STOP_SDA  = 3'd4,
        ST_STOP_RISE = 3'd5,
        ST_STOP_REL  = 3'd6
    } unstick_state_e;

    // Line drive and phase-length selection for one state
    typedef struct packed {
        logic scl_low;
        logic sda_low;
        logic active;
        logic use_high;
    } drive_t;

    function automatic drive_t drive_of(unstick_state_e s);
        drive_t d;
        d = '0;
        case (s)
            ST_PULSE_LO:  begin d.scl_low = 1'b1; d.active = 1'b1; end
            ST_PULSE_HI:  begin d.active = 1'b1; d.use_high = 1'b1; end
            ST_STOP_SCL:  begin d.scl_low = 1'b1; d.active = 1'b1; end
            ST_STOP_SDA:  begin d.scl_low = 1'b1; d.sda_low = 1'b1; d.active = 1'b1; end
            ST_STOP_RISE: begin d.sda_low = 1'b1; d.active = 1'b1; d.use_high = 1'b1; end
            ST_STOP_REL:  begin d.active = 1'b1; d.use_high = 1'b1; end
            default:      d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/unstick_timer.sv
module unstick_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;

    assign expire = tick && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
    import unstick_pkg::*;
#(
    parameter int MAX_PULSES = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic           sda_in,
    input  logic           scl_in,
    input  logic           expire,
    output unstick_state_e state,
    output unstick_state_e state_nxt,
    output logic           restart,
    output logic           done,
    output logic           failed
);
    localparam int CW = $clog2(MAX_PULSES + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_PULSES - 1);

    logic [CW-1:0] pulses;
    logic done_set, fail_set, clr, pulse_inc;

    always_comb begin
        state_nxt = state;
        done_set  = 1'b0;
        fail_set  = 1'b0;
        clr       = 1'b0;
        pulse_inc = 1'b0;
        case (state)
            ST_IDLE: begin
                if (go) begin
                    clr = 1'b1;
                    if (sda_in && scl_in)
                        done_set = 1'b1;
                    else if (sda_in)
                        state_nxt = ST_STOP_SCL;
                    else
                        state_nxt = ST_PULSE_LO;
                end
            end
            ST_PULSE_LO: if (expire) state_nxt = ST_PULSE_HI;
            ST_PULSE_HI: begin
                if (expire) begin
                    if (sda_in) begin
                        state_nxt = ST_STOP_SCL;
                    end else if (pulses == LAST) begin
                        state_nxt = ST_IDLE;
                        done_set  = 1'b1;
                        fail_set  = 1'b1;
                    end else begin
                        state_nxt = ST_PULSE_LO;
                        pulse_inc = 1'b1;
                    end
                end
            end
            ST_STOP_SCL:  if (expire) state_nxt = ST_STOP_SDA;
            ST_STOP_SDA:  if (expire) state_nxt = ST_STOP_RISE;
            ST_STOP_RISE: if (expire) state_nxt = ST_STOP_REL;
            ST_STOP_REL: begin
                if (expire) begin
                    state_nxt = ST_IDLE;
                    done_set  = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign restart = (state_nxt != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pulses <= '0;
            done   <= 1'b0;
            failed <= 1'b0;
        end else begin
            state  <= state_nxt;
            if (clr)
                pulses <= '0;
            else if (pulse_inc)
                pulses <= pulses + 1'b1;
            done   <= done_set | (done & ~clr);
            failed <= fail_set | (failed & ~clr);
        end
    end
endmodule

// File: rtl/unstick_drive.sv
module unstick_drive
    import unstick_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  unstick_state_e state_nxt,
    output logic           scl_drive_low,
    output logic           sda_drive_low,
    output logic           busy
);
    drive_t nxt_d;

    assign nxt_d = drive_of(state_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_drive_low <= 1'b0;
            sda_drive_low <= 1'b0;
            busy          <= 1'b0;
        end else begin
            scl_drive_low <= nxt_d.scl_low;
            sda_drive_low <= nxt_d.sda_low;
            busy          <= nxt_d.active;
        end
    end
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
    import unstick_pkg::*;
#(
    parameter int TW         = 4,
    parameter int MAX_PULSES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          recover_go,
    input  logic          sda_in,
    input  logic          scl_in,
    input  logic          tick,
    input  logic [TW-1:0] lo_ticks,
    input  logic [TW-1:0] hi_ticks,
    output logic          scl_drive_low,
    output logic          sda_drive_low,
    output logic          busy,
    output logic          recover_done,
    output logic          recover_failed
);
    unstick_state_e state, state_nxt;
    logic           restart, expire;
    logic [TW-1:0]  limit;
    drive_t         cur_d;

    assign cur_d = drive_of(state);
    assign limit = cur_d.use_high ? hi_ticks : lo_ticks;

    unstick_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .limit   (limit),
        .expire  (expire)
    );

    unstick_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (recover_go),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .expire    (expire),
        .state     (state),
        .state_nxt (state_nxt),
        .restart   (restart),
        .done      (recover_done),
        .failed    (recover_failed)
    );

    unstick_drive u_drive (
        .clk           (clk),
        .rst           (rst),
        .state_nxt     (state_nxt),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .busy          (busy)
    );
endmodule

// File: rtl/unstick_checker.sv
module unstick_checker #(
    parameter int MAX_PULSES = 8
) (
    input logic clk,
    input logic rst,
    input logic recover_go,
    input logic sda_in,
    input logic scl_in,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic busy,
    input logic recover_done,
    input logic recover_failed
);
    logic [7:0] low_eps;

    always_ff @(posedge clk) begin
        if (rst)
            low_eps <= '0;
        else if (recover_go && !busy)
            low_eps <= '0;
        else if (scl_drive_low && !$past(scl_drive_low))
            low_eps <= low_eps + 1'b1;
    end

    a_r2_idle_bus_done: assert property (@(posedge clk) disable iff (rst)
        recover_go && !busy && sda_in && scl_in |=> recover_done && !busy && !recover_failed);

    a_r5_fail_implies_done: assert property (@(posedge clk) disable iff (rst)
        recover_failed |-> recover_done);

    a_r5_pulse_cap: assert property (@(posedge clk) disable iff (rst)
        low_eps <= 8'(MAX_PULSES + 1));

    a_r6_sda_low_after_scl: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> scl_drive_low && $past(scl_drive_low));

    a_r6_stop_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_drive_low) |-> !scl_drive_low);

    a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
        recover_done && !recover_go |=> recover_done);

    a_r7_not_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !recover_done);

    a_r9_scl_only_busy: assert property (@(posedge clk) disable iff (rst)
        scl_drive_low |-> busy);

    a_r9_sda_only_busy: assert property (@(posedge clk) disable iff (rst)
        sda_drive_low |-> busy);
endmodule

bind i2c_unstick_seq unstick_checker #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .recover_go     (recover_go),
    .sda_in         (sda_in),
    .scl_in         (scl_in),
    .scl_drive_low  (scl_drive_low),
    .sda_drive_low  (sda_drive_low),
    .busy           (busy),
    .recover_done   (recover_done),
    .recover_failed (recover_failed)
);

// File: tb/i2c_unstick_seq_test.sv
`timescale 1ns/1ps
module i2c_unstick_seq_test;
    localparam int TW   = 4;
    localparam int MAXP = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, start, tick, scl_stuck;
    logic [TW-1:0] lo_t, hi_t;
    logic scl_drive_low, sda_drive_low, busy, done, failed;
    logic sda_in, scl_in, tgt_low;
    int hold, tick_per, tc;
    int rises, lows, sda_eps, order_bad, first_low_len, first_high_len;
    logic prev_scl, prev_sda;
    int total, bad, cycles;

    i2c_unstick_seq #(.TW(TW), .MAX_PULSES(MAXP)) uut (
        .clk(clk), .rst(rst), .recover_go(start), .sda_in(sda_in), .scl_in(scl_in),
        .tick(tick), .lo_ticks(lo_t), .hi_ticks(hi_t),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .busy(busy),
        .recover_done(done), .recover_failed(failed)
    );

    // Target model: holds SDA low until it has seen `hold` SCL rising edges
    assign tgt_low = (hold > 0) && (rises < hold);
    assign sda_in  = !sda_drive_low && !tgt_low;
    assign scl_in  = !scl_drive_low && !scl_stuck;
    assign tick    = (tc == 0);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (tc >= tick_per - 1) tc <= 0;
        else tc <= tc + 1;
    end

    always @(negedge clk) begin
        if (scl_drive_low && !prev_scl) lows = lows + 1;
        if (!scl_drive_low && prev_scl) rises = rises + 1;
        if (sda_drive_low && !prev_sda) sda_eps = sda_eps + 1;
        if (!sda_drive_low && prev_sda && scl_drive_low) order_bad = order_bad + 1;
        if (scl_drive_low && lows == 1) first_low_len = first_low_len + 1;
        if (!scl_drive_low && lows == 1 && busy) first_high_len = first_high_len + 1;
        prev_scl = scl_drive_low;
        prev_sda = sda_drive_low;
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int h, input int lo, input int hi, input int p,
                       input bit stuck, input bit poke);
        int n;
        int exp_lows, exp_sda;
        bit exp_fail, idle_case;
        @(posedge clk);
        hold = h; lo_t = TW'(lo); hi_t = TW'(hi); tick_per = p; scl_stuck = stuck;
        rises = 0; lows = 0; sda_eps = 0; order_bad = 0;
        first_low_len = 0; first_high_len = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        idle_case = (h == 0) && !stuck;
        if (idle_case) begin
            chk(done && !busy && !failed, "R2 done one cycle after strobe on idle bus", {done, busy, failed}, 3'b100);
            chk(lows == 0 && sda_eps == 0, "R2 no line driven on idle bus", lows + sda_eps, 0);
        end else begin
            chk(!done && busy, "R7 strobe clears done and starts", {done, busy}, 2'b01);
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
            start = (poke && n == 6) ? 1'b1 : 1'b0;
        end
        start = 1'b0;
        chk(n < 5000, "R7 recovery completes", n, 0);
        repeat (3) @(negedge clk);
        exp_fail = (h > MAXP);
        exp_lows = (h == 0) ? (stuck ? 1 : 0) : (exp_fail ? MAXP : h + 1);
        exp_sda  = (idle_case || exp_fail) ? 0 : 1;
        chk(done, "R7 done holds after completion", done, 1);
        chk(failed == exp_fail, exp_fail ? "R5 fail flag after last pulse" : "R4 no fail when released",
            failed, exp_fail);
        chk(lows == exp_lows, (h == 0) ? "R10 STOP only, no pulses" : (exp_fail ? "R5 pulse cap" :
            (poke ? "R8 busy strobe ignored" : "R4 pulses stop on release")), lows, exp_lows);
        chk(sda_eps == exp_sda, exp_fail ? "R5 no STOP on failure" : "R6 single STOP", sda_eps, exp_sda);
        chk(order_bad == 0, "R6 SDA released only with SCL released", order_bad, 0);
        chk(!scl_drive_low && !sda_drive_low && !busy, "R9 lines free when idle",
            {scl_drive_low, sda_drive_low, busy}, 0);
        if (h >= 1) begin
            chk(first_low_len >= lo * p + 1 && first_low_len <= (lo + 1) * p,
                "R3 low phase width", first_low_len, (lo + 1) * p);
        end
        if (h >= 2) begin
            chk(first_high_len >= hi * p + 1 && first_high_len <= (hi + 1) * p,
                "R3 high phase width", first_high_len, (hi + 1) * p);
        end
    endtask

    initial begin
        total = 0; bad = 0; cycles = 0; tc = 0;
        rst = 1'b1; start = 1'b0; hold = 0; tick_per = 1; scl_stuck = 1'b0;
        lo_t = '0; hi_t = '0;
        rises = 0; lows = 0; sda_eps = 0; order_bad = 0;
        first_low_len = 0; first_high_len = 0;
        prev_scl = 1'b0; prev_sda = 1'b0;
        repeat (4) @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low && !busy && !done && !failed,
            "R1 reset state", {scl_drive_low, sda_drive_low, busy, done, failed}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low && !busy && !done && !failed,
            "R1 state after reset release", {scl_drive_low, sda_drive_low, busy, done, failed}, 0);

        for (int h = 0; h <= 10; h++)
            for (int li = 0; li < 2; li++)
                for (int hj = 0; hj < 2; hj++)
                    for (int pk = 0; pk < 2; pk++)
                        run(h, li * 2, hj * 3, pk * 2 + 1, 1'b0, 1'b0);

        run(0, 1, 1, 1, 1'b1, 1'b0);   // R10: SDA high, SCL stuck low
        run(5, 2, 3, 1, 1'b0, 1'b1);   // R8: strobe while busy
        run(9, 0, 0, 1, 1'b0, 1'b0);   // R5 then R7: next run clears fail
        run(0, 0, 0, 1, 1'b0, 1'b0);
        chk(!failed, "R7 fail cleared by new strobe", failed, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule